// File: doc/BRIEF.md
# Local Control Register with Software-Driven Serial EEPROM Port

This block holds one 32-bit control and status word that a host reaches over a simple register bus. Part of the word is plain storage that drives device pins: a gate for a buffered UART clock output, a power-down filter code, a wake enable for a second function, and the clock, chip-select and data lines of a serial EEPROM. Software makes every EEPROM clock edge itself by rewriting the clock bit. Other bits report live input levels: a mode strap, the EEPROM's serial output, and a flag saying that a valid EEPROM image was found. The two asynchronous pins pass through a synchroniser before they can be read.

A two-bit field of the word picks which byte lane of a 32-bit host access connects to 8-bit peripherals. A peripheral read byte is placed on that lane and the other lanes are zero. A peripheral write byte is taken from that lane of the host write data. Host accesses come in two kinds. Memory accesses are DWORD aligned and use byte enables. I/O accesses move a single byte, which is chosen by the low two address bits.

Top module: `lcl_ctrl_reg`

## Requirements
- R1: While reset is asserted and directly after it, every stored field is zero. The EEPROM clock, chip-select and data pins are low, the UART clock output is low, and the read data bus is zero.
- R2: Bit 0 reads the mode pin after a two-flop synchroniser, so a read strobe at edge N returns the pin as sampled at edge N-2. Bit 1 always reads zero.
- R3: When bit 2 is 1, uart_clk_out follows uart_clk. When bit 2 is 0, uart_clk_out is held low.
- R4: Bits 4:3 select the peripheral byte lane. 00 selects bits 7:0, 01 bits 15:8, 10 bits 23:16 and 11 bits 31:24. per_lane_rdata carries per_rdata on the selected lane and zero on all other lanes. per_wdata is the selected lane of bus_wdata.
- R5: Bits 6:5 drive pd_filter and bit 7 drives wake_en. Both are writable and read back as written.
- R6: Bits 24, 25 and 26 drive ee_ck, ee_cs and ee_do. They change only on a write that hits the register.
- R7: Bit 27 reads ee_di through the same two-flop synchroniser used for the mode pin. Bit 28 reads the ee_valid input as it is at the read edge.
- R8: A memory write (bus_io=0) updates each byte whose bus_be bit is set. An I/O write (bus_io=1) ignores bus_be and updates only the byte numbered bus_addr[1:0], taking it from that byte's lane of bus_wdata.
- R9: Read data is registered and appears on the cycle after the read strobe. It is zero in every cycle that follows no read. A memory read returns the lanes enabled by bus_be, and an I/O read returns only lane bus_addr[1:0]. All other lanes read zero. Bits 1, 23:8 and 31:29 always read zero, and writes to them or to bits 0, 27 and 28 have no effect.
- R10: The register occupies the DWORD at byte offset REG_OFS (default 0). A read of any other DWORD returns zero, and a write to any other DWORD changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_io | input | 1 | 1 = single-byte I/O access, 0 = DWORD memory access |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte enables for memory accesses |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Registered host read data |
| mode_pin | input | 1 | Asynchronous mode strap |
| uart_clk | input | 1 | UART reference clock |
| uart_clk_out | output | 1 | Gated copy of uart_clk |
| pd_filter | output | 2 | Power-down filter code |
| wake_en | output | 1 | Second-function wake enable |
| ee_ck | output | 1 | EEPROM serial clock |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_do | output | 1 | Serial data into the EEPROM |
| ee_di | input | 1 | Serial data from the EEPROM, asynchronous |
| ee_valid | input | 1 | Valid EEPROM image detected |
| per_rdata | input | PER_W | Byte read from an 8-bit peripheral |
| per_wdata | output | PER_W | Byte sent to an 8-bit peripheral |
| per_lane_rdata | output | 32 | Peripheral byte steered onto the selected lane |

## Verification
The EEPROM pins are driven with a bit-banged sequence of separate clock-high and clock-low writes. This shows whether each pin tracks its own bit and stays steady between writes. All four lane codes are tried with varying peripheral and host bytes, which exposes a swapped lane or a lane that leaks into its neighbours. I/O byte writes and reads at each of the four byte addresses, memory writes with partial enables, and accesses to other DWORD offsets show apart the byte-enable path, the I/O byte path and the address decode. Toggling the mode and EEPROM data pins between back-to-back reads pins down the exact synchroniser latency.

// File: rtl/lcr_pkg.sv
package lcr_pkg;
   localparam int unsigned CTL_W     = 32;
   localparam int unsigned BYTE_W    = 8;
   localparam int unsigned N_BYTES   = CTL_W / BYTE_W;
   localparam int unsigned LANE_SW   = 2;

   localparam int unsigned B_MODE    = 0;
   localparam int unsigned B_CLKEN   = 2;
   localparam int unsigned B_LANE    = 3;
   localparam int unsigned B_PDF     = 5;
   localparam int unsigned B_WAKE    = 7;
   localparam int unsigned B_EECK    = 24;
   localparam int unsigned B_EECS    = 25;
   localparam int unsigned B_EEDO    = 26;
   localparam int unsigned B_EEDI    = 27;
   localparam int unsigned B_EEVLD   = 28;

   // storage bits: 7:2 and 26:24
   localparam logic [CTL_W-1:0] WR_MASK = 32'h0700_00FC;

   typedef struct packed {
      logic       ee_do;
      logic       ee_cs;
      logic       ee_ck;
      logic       wake;
      logic [1:0] pdf;
      logic [1:0] lane;
      logic       clken;
   } ctl_t;

   function automatic logic [N_BYTES-1:0] io_byte_en(input logic [1:0] a);
      return N_BYTES'(1) << a;
   endfunction
endpackage

// File: rtl/lcr_sync.sv
module lcr_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("lcr_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/lcr_lane.sv
module lcr_lane #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LANE_W = 8
) (
   input  logic [$clog2(DATA_W/LANE_W)-1:0] sel,
   input  logic [DATA_W-1:0]                host_wdata,
   input  logic [LANE_W-1:0]                per_rdata,
   output logic [LANE_W-1:0]                per_wdata,
   output logic [DATA_W-1:0]                lane_rdata
);
   localparam int unsigned NL = DATA_W / LANE_W;
   localparam int unsigned SW = $clog2(NL);

   if (NL * LANE_W != DATA_W || NL < 2) begin : g_bad_split
      $error("lcr_lane: DATA_W must be a multiple (>=2) of LANE_W");
   end

   for (genvar g = 0; g < NL; g++) begin : g_rd
      assign lane_rdata[g*LANE_W +: LANE_W] = (sel == SW'(g)) ? per_rdata : '0;
   end

   always_comb begin
      per_wdata = '0;
      for (int i = 0; i < NL; i++) begin
         if (sel == SW'(i)) per_wdata = host_wdata[i*LANE_W +: LANE_W];
      end
   end
endmodule

// File: rtl/lcr_regfile.sv
module lcr_regfile
   import lcr_pkg::*;
#(
   parameter logic [CTL_W-1:0] MASK = WR_MASK
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [N_BYTES-1:0] be,
   input  logic [CTL_W-1:0]   wdata,
   output logic [CTL_W-1:0]   store
);
   for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
      localparam logic [BYTE_W-1:0] BM = MASK[b*BYTE_W +: BYTE_W];
      if (BM != '0) begin : g_kept
         logic [BYTE_W-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               r <= '0;
            else if (wr_en && be[b])
               r <= wdata[b*BYTE_W +: BYTE_W] & BM;
         end
         assign store[b*BYTE_W +: BYTE_W] = r;
      end else begin : g_empty
         assign store[b*BYTE_W +: BYTE_W] = '0;
      end
   end
endmodule

// File: rtl/lcl_ctrl_reg.sv
module lcl_ctrl_reg
   import lcr_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned REG_OFS     = 0,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned PER_W       = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic               bus_io,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [3:0]         bus_be,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic               mode_pin,
   input  logic               uart_clk,
   output logic               uart_clk_out,
   output logic [1:0]         pd_filter,
   output logic               wake_en,
   output logic               ee_ck,
   output logic               ee_cs,
   output logic               ee_do,
   input  logic               ee_di,
   input  logic               ee_valid,
   input  logic [PER_W-1:0]   per_rdata,
   output logic [PER_W-1:0]   per_wdata,
   output logic [31:0]        per_lane_rdata
);
   localparam logic [ADDR_W-1:0] OFS_V = ADDR_W'(REG_OFS);

   if (ADDR_W < 3) begin : g_bad_addr
      $error("lcl_ctrl_reg: ADDR_W must be at least 3");
   end
   if (PER_W * N_BYTES != CTL_W) begin : g_bad_lane
      $error("lcl_ctrl_reg: the lane field needs exactly four lanes");
   end
   if (OFS_V[1:0] != 2'b00) begin : g_bad_ofs
      $error("lcl_ctrl_reg: REG_OFS must be DWORD aligned");
   end

   // address decode and effective byte enables
   logic               hit;
   logic [N_BYTES-1:0] eff_be;
   logic [CTL_W-1:0]   rd_mask;
   logic               do_rd;
   logic               do_wr;

   assign hit    = bus_sel && (bus_addr[ADDR_W-1:2] == OFS_V[ADDR_W-1:2]);
   assign eff_be = bus_io ? io_byte_en(bus_addr[1:0]) : bus_be;
   assign do_rd  = bus_sel && !bus_wr;
   assign do_wr  = hit && bus_wr;

   for (genvar b = 0; b < N_BYTES; b++) begin : g_mask
      assign rd_mask[b*BYTE_W +: BYTE_W] = {BYTE_W{eff_be[b]}};
   end

   // storage
   logic [CTL_W-1:0] store_q;
   ctl_t             ctl;

   lcr_regfile #(.MASK(WR_MASK)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (do_wr),
      .be    (eff_be),
      .wdata (bus_wdata),
      .store (store_q)
   );

   assign ctl = {store_q[B_EEDO], store_q[B_EECS], store_q[B_EECK],
                 store_q[B_WAKE], store_q[B_PDF +: 2], store_q[B_LANE +: LANE_SW],
                 store_q[B_CLKEN]};

   // pin synchroniser: bit 1 = EEPROM data, bit 0 = mode strap
   logic [1:0] pins_s;

   lcr_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ee_di, mode_pin}),
      .q     (pins_s)
   );

   // read image and registered read port
   logic [CTL_W-1:0] image;

   always_comb begin
      image           = store_q;
      image[B_MODE]   = pins_s[0];
      image[B_EEDI]   = pins_s[1];
      image[B_EEVLD]  = ee_valid;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bus_rdata <= '0;
      else if (do_rd && hit)
         bus_rdata <= image & rd_mask;
      else
         bus_rdata <= '0;
   end

   // pin drive
   assign uart_clk_out = uart_clk & ctl.clken;
   assign pd_filter    = ctl.pdf;
   assign wake_en      = ctl.wake;
   assign ee_ck        = ctl.ee_ck;
   assign ee_cs        = ctl.ee_cs;
   assign ee_do        = ctl.ee_do;

   // peripheral lane steering
   lcr_lane #(.DATA_W(CTL_W), .LANE_W(PER_W)) u_lane (
      .sel        (ctl.lane),
      .host_wdata (bus_wdata),
      .per_rdata  (per_rdata),
      .per_wdata  (per_wdata),
      .lane_rdata (per_lane_rdata)
   );
endmodule

// File: rtl/lcr_chk.sv
module lcr_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        bus_sel,
   input logic        bus_wr,
   input logic        hit,
   input logic [31:0] bus_rdata,
   input logic [31:0] store,
   input logic        uart_clk_out,
   input logic        ee_ck,
   input logic        ee_cs,
   input logic        ee_do,
   input logic [31:0] per_lane_rdata
);
   AST_CLKOUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !store[2] |-> !uart_clk_out); // R3

   AST_LANE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
      (per_lane_rdata & ~(32'h0000_00FF << {store[4:3], 3'b000})) == 32'h0); // R4

   AST_EE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_wr && hit) |=> $stable({ee_ck, ee_cs, ee_do})); // R6

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata[31:29] == 3'b0) && (bus_rdata[23:8] == 16'h0) && !bus_rdata[1]); // R9

   AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && !bus_wr) |=> (bus_rdata == 32'h0)); // R9

   AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && !hit) |=> $stable(store)); // R10
endmodule

bind lcl_ctrl_reg lcr_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .bus_sel        (bus_sel),
   .bus_wr         (bus_wr),
   .hit            (hit),
   .bus_rdata      (bus_rdata),
   .store          (store_q),
   .uart_clk_out   (uart_clk_out),
   .ee_ck          (ee_ck),
   .ee_cs          (ee_cs),
   .ee_do          (ee_do),
   .per_lane_rdata (per_lane_rdata)
);

// File: tb/sim_lcl_ctrl_reg.sv
`timescale 1ns/100ps
module sim_lcl_ctrl_reg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 0, bus_wr = 0, bus_io = 0;
   logic [7:0]  bus_addr = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        mode_pin = 0, uart_clk = 0, uart_clk_out;
   logic [1:0]  pd_filter;
   logic        wake_en, ee_ck, ee_cs, ee_do;
   logic        ee_di = 0, ee_valid = 0;
   logic [7:0]  per_rdata = '0, per_wdata;
   logic [31:0] per_lane_rdata;

   always #2.5 clk = ~clk;
   always #3   uart_clk = ~uart_clk;

   lcl_ctrl_reg u0 (.*);

   int    n_chk = 0;
   int    n_fail = 0;
   string cur_req = "R1";

   // behavioural reference
   logic [31:0] m_store = '0;
   logic [31:0] m_rdata = '0;
   logic [1:0]  m_pipe [$] = '{2'b00, 2'b00};

   function automatic logic [31:0] lanes(input logic [3:0] be);
      logic [31:0] m = '0;
      for (int b = 0; b < 4; b++) if (be[b]) m[b*8 +: 8] = 8'hFF;
      return m;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_store = '0;
         m_rdata = '0;
         m_pipe  = '{2'b00, 2'b00};
      end else begin
         logic [31:0] img;
         logic [3:0]  be;
         logic        hit;
         img = m_store | (32'(ee_valid) << 28) | (32'(m_pipe[0][1]) << 27) | 32'(m_pipe[0][0]);
         be  = bus_io ? (4'b0001 << bus_addr[1:0]) : bus_be;
         hit = bus_sel && (bus_addr[7:2] == 6'd0);
         if (bus_sel && !bus_wr && hit) m_rdata = img & lanes(be);
         else                           m_rdata = '0;
         if (hit && bus_wr)
            m_store = (m_store & ~lanes(be)) | (bus_wdata & lanes(be) & 32'h0700_00FC);
         void'(m_pipe.pop_front());
         m_pipe.push_back({ee_di, mode_pin});
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h at %0t", req, what, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      logic [1:0] ln;
      ln = m_store[4:3];
      chk(cur_req, "bus_rdata", bus_rdata, m_rdata);
      chk("R3", "uart_clk_out", 32'(uart_clk_out), 32'(uart_clk & m_store[2]));
      chk("R4", "per_lane_rdata", per_lane_rdata, 32'(per_rdata) << (8 * ln));
      chk("R4", "per_wdata", 32'(per_wdata), (bus_wdata >> (8 * ln)) & 32'hFF);
      chk("R5", "pd_filter/wake_en", {29'b0, wake_en, pd_filter}, {29'b0, m_store[7:5]});
      chk("R6", "ee pins", {29'b0, ee_do, ee_cs, ee_ck}, {29'b0, m_store[26:24]});
   end

   task automatic op(input logic s, input logic w, input logic io, input logic [7:0] a,
                     input logic [3:0] be, input logic [31:0] d);
      @(posedge clk); #1;
      bus_sel = s; bus_wr = w; bus_io = io; bus_addr = a; bus_be = be; bus_wdata = d;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) op(0, 0, 0, 8'h00, 4'h0, bus_wdata);
   endtask

   task automatic mwr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
      op(1, 1, 0, a, be, d);
   endtask

   task automatic mrd(input logic [7:0] a, input logic [3:0] be);
      op(1, 0, 0, a, be, 32'h0);
   endtask

   initial begin
      // R1: reset state
      cur_req = "R1";
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      mrd(8'h00, 4'hF);
      idle(2);

      // R6: bit-banged EEPROM sequence
      cur_req = "R6";
      mwr(8'h00, 4'h8, 32'h0200_0000);
      for (int k = 0; k < 4; k++) begin
         logic [31:0] bitv;
         bitv = (k[0]) ? 32'h0400_0000 : 32'h0;
         mwr(8'h00, 4'h8, 32'h0200_0000 | bitv);
         idle(1);
         mwr(8'h00, 4'h8, 32'h0300_0000 | bitv);
         idle(1);
      end
      mwr(8'h00, 4'h8, 32'h0);
      mrd(8'h00, 4'hF);

      // R5: filter code and wake enable
      cur_req = "R5";
      mwr(8'h00, 4'h1, 32'h0000_00A0);
      mrd(8'h00, 4'h1);
      mwr(8'h00, 4'h1, 32'h0000_0060);
      mrd(8'h00, 4'h1);

      // R3: UART clock gate on and off
      cur_req = "R3";
      mwr(8'h00, 4'h1, 32'h0000_0004);
      idle(6);
      mwr(8'h00, 4'h1, 32'h0000_0000);
      idle(6);

      // R4: each lane code with varying data
      cur_req = "R4";
      for (int l = 0; l < 4; l++) begin
         mwr(8'h00, 4'h1, 32'(l) << 3);
         for (int j = 0; j < 3; j++) begin
            per_rdata = 8'(8'h3C + 17 * (l * 3 + j));
            op(0, 0, 0, 8'h00, 4'h0, 32'hA1B2_C3D4 ^ (32'(j) * 32'h0101_0101));
         end
         mrd(8'h00, 4'h1);
      end

      // R2, R7: synchroniser latency on mode and EEPROM data, valid flag
      cur_req = "R2";
      mode_pin = 1; mrd(8'h00, 4'h1); mrd(8'h00, 4'h1); mrd(8'h00, 4'h1); mrd(8'h00, 4'h1);
      mode_pin = 0; mrd(8'h00, 4'h1); mrd(8'h00, 4'h1); mrd(8'h00, 4'h1);
      cur_req = "R7";
      ee_di = 1; ee_valid = 1;
      mrd(8'h00, 4'h8); mrd(8'h00, 4'h8); mrd(8'h00, 4'h8); mrd(8'h00, 4'h8);
      ee_di = 0;
      mrd(8'h00, 4'h8); mrd(8'h00, 4'h8); mrd(8'h00, 4'h8);
      ee_valid = 0; mrd(8'h00, 4'h8);

      // R8: byte-enable writes and I/O byte writes/reads
      cur_req = "R8";
      mwr(8'h00, 4'h8, 32'hFFFF_FFFF);
      mrd(8'h00, 4'hF);
      mwr(8'h00, 4'h1, 32'h0000_0018);
      mrd(8'h00, 4'hF);
      for (int a = 0; a < 4; a++) begin
         op(1, 1, 1, 8'(a), 4'h0, 32'h0000_0000);
         op(1, 0, 1, 8'(a), 4'h0, 32'h0);
      end
      op(1, 1, 1, 8'h03, 4'h1, 32'h0500_00FF);
      op(1, 0, 1, 8'h03, 4'h0, 32'h0);
      op(1, 1, 1, 8'h00, 4'h8, 32'hFF00_00E8);
      op(1, 0, 1, 8'h00, 4'h0, 32'h0);
      op(1, 0, 1, 8'h03, 4'h0, 32'h0);

      // R9: reserved and read-only bits, lane masking on reads
      cur_req = "R9";
      mode_pin = 1; ee_di = 1; ee_valid = 1;
      idle(3);
      mwr(8'h00, 4'hF, 32'hFFFF_FFFF);
      mrd(8'h00, 4'hF);
      mwr(8'h00, 4'hF, 32'h0000_0000);
      mrd(8'h00, 4'hF);
      mrd(8'h00, 4'h6);
      mrd(8'h00, 4'h0);
      mode_pin = 0; ee_di = 0; ee_valid = 0;
      idle(3);

      // R10: other offsets
      cur_req = "R10";
      mwr(8'h00, 4'hF, 32'h0500_00C4);
      mwr(8'h04, 4'hF, 32'hFFFF_FFFF);
      mwr(8'h40, 4'hF, 32'h0000_0000);
      op(1, 1, 1, 8'h05, 4'h0, 32'h0000_FF00);
      mrd(8'h04, 4'hF);
      mrd(8'hFC, 4'hF);
      mrd(8'h00, 4'hF);

      // mixed traffic, R8 and R4 together
      cur_req = "R8";
      for (int i = 0; i < 200; i++) begin
         logic [31:0] h;
         h = 32'(i) * 32'h9E37_79B9;
         per_rdata = h[15:8];
         mode_pin = h[3]; ee_di = h[17]; ee_valid = h[21];
         op(h[0] | h[1], h[2], h[4], {h[9] & h[10], 5'b0, h[6:5]}, h[14:11], h ^ 32'h5A5A_A5A5);
      end
      idle(4);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(400_000);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule